// File: doc/BRIEF.md
# Ethernet Transmit Frame Builder

This block turns one frame's worth of bytes, held in a show-ahead byte FIFO, into a serial stream on a transmit interface that is `TX_W` bits wide. It waits in idle until two things are true: the FIFO holds at least a programmed number of bytes, and the channel-permit input is high. It then sends a fixed preamble and a start delimiter, followed by the payload bytes up to the one flagged as end of frame. Zero bytes may be added to bring a short frame up to the minimum length. The frame closes with a CRC-32 check sequence.

Pad insertion and check-sequence generation are chosen frame by frame. Both selects, like the threshold, are captured when the frame starts. If the FIFO runs dry before the end-of-frame byte arrives, the frame is cut short and an underrun pulse is raised instead of the done pulse. Each byte goes out least significant bit first. On a lane narrower than a byte, the lower-order slice is sent first.

Top module: `txb_frame_tx`

## Requirements
- R1: A frame starts only from idle, and only after a cycle in which `chan_ok` is high, `fifo_level` is non-zero and `fifo_level` >= `fill_thresh`. Otherwise `tx_en` stays low.
- R2: Every frame opens with seven bytes of value 8'h55 (bit 0 sent first, so the line shows 1,0,1,0...) and then one delimiter byte 8'hD5. With `TX_W`=4 each byte is sent as bits [3:0] and then bits [7:4].
- R3: After the delimiter, the payload bytes appear in FIFO order, up to and including the byte whose `fifo_eof` is high.
- R4: With the check sequence on, four bytes follow the data. They are the bitwise complement of a reflected CRC-32 (polynomial 04C11DB7h, register preset to all ones) computed over every data and pad byte, lowest-order byte first. A receiver running the same CRC over data plus check sequence ends with the register at 32'hDEBB20E3.
- R5: With pad and check sequence both on, zero bytes are inserted after a short payload until payload plus pad equals 60 bytes, so the frame reaches 64 bytes including the check sequence. Payloads of 60 bytes or more get no pad.
- R6: With pad on and check sequence off, zero bytes are inserted until the frame reaches 64 bytes.
- R7: With pad off, a short payload is sent at its own length.
- R8: With the check sequence off, nothing is sent after the last payload or pad byte.
- R9: `tx_en` is high without a gap from the first preamble beat to the last beat of the frame. `tx_done` is a one-cycle pulse in the first cycle after a complete frame, in which `tx_en` is already low.
- R10: If the FIFO is empty when the next payload byte is needed and no end-of-frame byte has been read, `tx_en` drops after the current byte and `tx_underrun` pulses for one cycle. No check sequence and no `tx_done` follow.
- R11: `pad_on`, `fcs_on` and `fill_thresh` are sampled when the frame starts. Changing them during a frame does not alter that frame.
- R12: `fifo_rd` pops exactly one byte for each payload byte sent. It is never high while the FIFO is empty or while `tx_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fifo_data | input | 8 | Head byte of the show-ahead FIFO |
| fifo_eof | input | 1 | Head byte is the last payload byte of the frame |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_level | input | LVL_W | Number of bytes in the FIFO |
| fifo_rd | output | 1 | Pop the head byte at this clock edge |
| fill_thresh | input | LVL_W | Fill level needed before a frame may start |
| chan_ok | input | 1 | Channel is free for transmission |
| pad_on | input | 1 | Enable zero padding to minimum frame size |
| fcs_on | input | 1 | Enable appending of the CRC-32 check sequence |
| tx_en | output | 1 | Transmit enable, high during the frame |
| tx_d | output | TX_W | Transmit data lane |
| tx_done | output | 1 | One-cycle pulse after a complete frame |
| tx_underrun | output | 1 | One-cycle pulse when a frame is aborted by FIFO underrun |

## Verification
The bound checker watches several rules on every cycle. A rise of `tx_en` must follow a cycle in which the start conditions held, and the first beat of a frame must be the preamble pattern. Pops must happen only while transmitting and from a non-empty FIFO. The done and underrun pulses must follow the fall of `tx_en`, and they never occur together.

Other behaviours can only be shown by the bench's scenarios. These are the order and content of the payload, the pad lengths at the 60- and 64-byte boundaries, the check-sequence value and its receiver residue, the point at which an underrun cuts the frame, and the per-frame capture of the mode selects. The bench compares each of these against its reference stream beat by beat.

// File: rtl/txb_pkg.sv
package txb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SFD,
    ST_DATA,
    ST_PAD,
    ST_FCS
  } txb_state_e;

  localparam logic [7:0] PRE_BYTE  = 8'h55;
  localparam logic [7:0] SFD_BYTE  = 8'hD5;
  localparam int         PRE_LEN   = 7;
  localparam int         FCS_LEN   = 4;
  localparam int         MIN_FRAME = 64;

  // Reflected CRC-32 step over one byte, LSB first.
  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 32'hEDB88320;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/txb_crc32.sv
module txb_crc32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [31:0] crc
);
  import txb_pkg::*;

  logic [31:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (init)     crc_d = 32'hFFFF_FFFF;
    else if (upd) crc_d = crc32_byte(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= 32'hFFFF_FFFF;
    else if (init || upd) crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/txb_lane_drv.sv
module txb_lane_drv #(
  parameter int TX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic [7:0]      byte_i,
  output logic            last_beat,
  output logic [TX_W-1:0] tx_d
);
  localparam int BEATS = 8 / TX_W;
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [BW-1:0] beat_q, beat_d;

  assign last_beat = (beat_q == BW'(BEATS - 1));

  always_comb begin
    beat_d = beat_q;
    if (!active)        beat_d = '0;
    else if (last_beat) beat_d = '0;
    else                beat_d = beat_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= '0;
    else        beat_q <= beat_d;
  end

  generate
    if (BEATS == 1) begin : g_byte_lane
      assign tx_d = active ? byte_i : '0;
    end else begin : g_narrow_lane
      assign tx_d = active ? byte_i[beat_q*TX_W +: TX_W] : '0;
    end
  endgenerate
endmodule

// File: rtl/txb_ctrl.sv
module txb_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_ok,
  input  logic        last_beat,
  input  logic [7:0]  fifo_data,
  input  logic        fifo_eof,
  input  logic        fifo_empty,
  input  logic        pad_on,
  input  logic        fcs_on,
  input  logic [31:0] crc,
  output logic        fifo_rd,
  output logic        crc_init,
  output logic        crc_upd,
  output logic [7:0]  crc_din,
  output logic        active,
  output logic [7:0]  byte_o,
  output logic        done,
  output logic        underrun
);
  import txb_pkg::*;

  localparam int CNT_W = $clog2(MIN_FRAME) + 1;
  localparam logic [CNT_W-1:0] PAD_FCS   = CNT_W'(MIN_FRAME - FCS_LEN);
  localparam logic [CNT_W-1:0] PAD_NOFCS = CNT_W'(MIN_FRAME);

  txb_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, pad_tgt;
  logic [7:0]       byte_q, byte_d, fcs_byte;
  logic             eof_q, eof_d, pad_q, pad_d, fcs_q, fcs_d;
  logic             done_q, done_d, unr_q, unr_d;
  logic             go_tail;
  logic [1:0]       fcs_sel;

  assign cnt_inc  = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;
  assign pad_tgt  = fcs_q ? PAD_FCS : PAD_NOFCS;
  assign fcs_sel  = (state_q == ST_FCS) ? cnt_q[1:0] : 2'd0;
  assign fcs_byte = ~crc[{fcs_sel, 3'b000} +: 8];

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    byte_d   = byte_q;
    eof_d    = eof_q;
    pad_d    = pad_q;
    fcs_d    = fcs_q;
    done_d   = 1'b0;
    unr_d    = 1'b0;
    fifo_rd  = 1'b0;
    crc_init = 1'b0;
    crc_upd  = 1'b0;
    crc_din  = 8'h00;
    go_tail  = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (start_ok) begin
          state_d  = ST_PRE;
          cnt_d    = CNT_W'(1);
          byte_d   = PRE_BYTE;
          pad_d    = pad_on;
          fcs_d    = fcs_on;
          eof_d    = 1'b0;
          crc_init = 1'b1;
        end
      end
      ST_PRE: begin
        if (last_beat) begin
          if (cnt_q == CNT_W'(PRE_LEN)) begin
            state_d = ST_SFD;
            byte_d  = SFD_BYTE;
          end else begin
            cnt_d = cnt_inc;
          end
        end
      end
      ST_SFD, ST_DATA: begin
        if (last_beat) begin
          if (state_q == ST_DATA && eof_q) begin
            go_tail = 1'b1;
          end else if (fifo_empty) begin
            state_d = ST_IDLE;
            unr_d   = 1'b1;
          end else begin
            fifo_rd = 1'b1;
            byte_d  = fifo_data;
            eof_d   = fifo_eof;
            crc_upd = 1'b1;
            crc_din = fifo_data;
            state_d = ST_DATA;
            cnt_d   = (state_q == ST_SFD) ? CNT_W'(1) : cnt_inc;
          end
        end
      end
      ST_PAD: begin
        if (last_beat) go_tail = 1'b1;
      end
      ST_FCS: begin
        if (last_beat) begin
          if (cnt_q == CNT_W'(FCS_LEN)) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            byte_d = fcs_byte;
            cnt_d  = cnt_inc;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (go_tail) begin
      if (pad_q && (cnt_q < pad_tgt)) begin
        state_d = ST_PAD;
        byte_d  = 8'h00;
        crc_upd = 1'b1;
        crc_din = 8'h00;
        cnt_d   = cnt_inc;
      end else if (fcs_q) begin
        state_d = ST_FCS;
        byte_d  = fcs_byte;
        cnt_d   = CNT_W'(1);
      end else begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      byte_q  <= '0;
      eof_q   <= 1'b0;
      pad_q   <= 1'b0;
      fcs_q   <= 1'b0;
      done_q  <= 1'b0;
      unr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      byte_q  <= byte_d;
      eof_q   <= eof_d;
      pad_q   <= pad_d;
      fcs_q   <= fcs_d;
      done_q  <= done_d;
      unr_q   <= unr_d;
    end
  end

  assign active   = (state_q != ST_IDLE);
  assign byte_o   = byte_q;
  assign done     = done_q;
  assign underrun = unr_q;
endmodule

// File: rtl/txb_frame_tx.sv
module txb_frame_tx #(
  parameter int TX_W  = 4,
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       fifo_data,
  input  logic             fifo_eof,
  input  logic             fifo_empty,
  input  logic [LVL_W-1:0] fifo_level,
  output logic             fifo_rd,
  input  logic [LVL_W-1:0] fill_thresh,
  input  logic             chan_ok,
  input  logic             pad_on,
  input  logic             fcs_on,
  output logic             tx_en,
  output logic [TX_W-1:0]  tx_d,
  output logic             tx_done,
  output logic             tx_underrun
);
  logic [1:0]  rsync_q;
  logic        rst_i_n;
  logic        start_ok, last_beat, active;
  logic        crc_init, crc_upd;
  logic [7:0]  crc_din, byte_w;
  logic [31:0] crc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  assign start_ok = chan_ok && (fifo_level != '0) && (fifo_level >= fill_thresh);

  txb_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .start_ok   (start_ok),
    .last_beat  (last_beat),
    .fifo_data  (fifo_data),
    .fifo_eof   (fifo_eof),
    .fifo_empty (fifo_empty),
    .pad_on     (pad_on),
    .fcs_on     (fcs_on),
    .crc        (crc),
    .fifo_rd    (fifo_rd),
    .crc_init   (crc_init),
    .crc_upd    (crc_upd),
    .crc_din    (crc_din),
    .active     (active),
    .byte_o     (byte_w),
    .done       (tx_done),
    .underrun   (tx_underrun)
  );

  txb_crc32 u_crc (
    .clk   (clk),
    .rst_n (rst_i_n),
    .init  (crc_init),
    .upd   (crc_upd),
    .din   (crc_din),
    .crc   (crc)
  );

  txb_lane_drv #(.TX_W(TX_W)) u_lane (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .active    (active),
    .byte_i    (byte_w),
    .last_beat (last_beat),
    .tx_d      (tx_d)
  );

  assign tx_en = active;
endmodule

// File: rtl/txb_frame_tx_chk.sv
module txb_frame_tx_chk #(
  parameter int TX_W  = 4,
  parameter int LVL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chan_ok,
  input logic [LVL_W-1:0] fifo_level,
  input logic [LVL_W-1:0] fill_thresh,
  input logic             fifo_empty,
  input logic             fifo_rd,
  input logic             tx_en,
  input logic [TX_W-1:0]  tx_d,
  input logic             tx_done,
  input logic             tx_underrun
);
  localparam logic [7:0] FIRST_BYTE = 8'h55;

  // R1
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> ($past(chan_ok) && $past(fifo_level) != '0 && $past(fifo_level) >= $past(fill_thresh)));

  // R2
  preamble_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> (tx_d == FIRST_BYTE[TX_W-1:0]));

  // R9
  done_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (!tx_en && $past(tx_en)));

  // R10
  underrun_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |-> (!tx_en && $past(tx_en) && !tx_done));

  // R12
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> (!fifo_empty && tx_en));
endmodule

bind txb_frame_tx txb_frame_tx_chk #(.TX_W(TX_W), .LVL_W(LVL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chan_ok     (chan_ok),
  .fifo_level  (fifo_level),
  .fill_thresh (fill_thresh),
  .fifo_empty  (fifo_empty),
  .fifo_rd     (fifo_rd),
  .tx_en       (tx_en),
  .tx_d        (tx_d),
  .tx_done     (tx_done),
  .tx_underrun (tx_underrun)
);

// File: tb/tb_txb_frame_tx.sv
`timescale 1ns/1ps
module tb_txb_frame_tx;
  localparam int TX_W  = 4;
  localparam int LVL_W = 8;

  logic             clk, rst_n;
  logic [7:0]       fifo_data;
  logic             fifo_eof, fifo_empty, fifo_rd;
  logic [LVL_W-1:0] fifo_level, fill_thresh;
  logic             chan_ok, pad_on, fcs_on;
  logic             tx_en, tx_done, tx_underrun;
  logic [TX_W-1:0]  tx_d;

  txb_frame_tx #(.TX_W(TX_W), .LVL_W(LVL_W)) dut (
    .clk(clk), .rst_n(rst_n), .fifo_data(fifo_data), .fifo_eof(fifo_eof),
    .fifo_empty(fifo_empty), .fifo_level(fifo_level), .fifo_rd(fifo_rd),
    .fill_thresh(fill_thresh), .chan_ok(chan_ok), .pad_on(pad_on), .fcs_on(fcs_on),
    .tx_en(tx_en), .tx_d(tx_d), .tx_done(tx_done), .tx_underrun(tx_underrun)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;

  logic [7:0] fq[$];
  logic       eq[$];
  logic [3:0] expq[$];
  logic [3:0] gotq[$];
  logic       rd_take = 1'b0;
  int mism = 0, en_cyc = 0, done_cnt = 0, unr_cnt = 0, rises = 0, exp_len = 0;
  logic prev_en = 1'b0;
  logic mon_on = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic drive_fifo();
    fifo_empty = (fq.size() == 0);
    fifo_level = LVL_W'(fq.size());
    fifo_data  = (fq.size() > 0) ? fq[0] : 8'h00;
    fifo_eof   = (eq.size() > 0) ? eq[0] : 1'b0;
  endtask

  // FIFO model: pop what the design took at the last edge, then sample the read for the next edge
  always @(negedge clk) begin
    if (rd_take) begin
      void'(fq.pop_front());
      void'(eq.pop_front());
    end
    drive_fifo();
    #2;
    rd_take = fifo_rd;
  end

  // Reference comparison on every clock
  always @(negedge clk) begin
    cycles++;
    if (mon_on) begin
      if (tx_en) begin
        en_cyc++;
        gotq.push_back(tx_d);
        if (expq.size() == 0) mism++;
        else if (expq.pop_front() !== tx_d) mism++;
      end
      if (tx_en && !prev_en) rises++;
      if (tx_done) done_cnt++;
      if (tx_underrun) unr_cnt++;
    end
    prev_en = tx_en;
  end

  initial begin
    while (cycles < 150000) @(negedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    repeat (8) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic exp_byte(input logic [7:0] b);
    expq.push_back(b[3:0]);
    expq.push_back(b[7:4]);
  endtask

  task automatic clear_mon();
    @(negedge clk); #1;
    mism = 0; en_cyc = 0; done_cnt = 0; unr_cnt = 0; rises = 0;
    gotq.delete(); expq.delete();
  endtask

  // Load FIFO and build the reference stream for one frame
  task automatic load_frame(input int n, input int seed, input bit pad, input bit fcs, input bit eof);
    logic [7:0] b;
    logic [31:0] c;
    int total;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 7; i++) exp_byte(8'h55);
    exp_byte(8'hD5);
    for (int i = 0; i < n; i++) begin
      b = 8'((i * 37 + seed) & 255);
      fq.push_back(b);
      eq.push_back(eof && (i == n - 1));
      exp_byte(b);
      c = ref_crc(c, b);
    end
    if (eof) begin
      total = n;
      if (pad) while (total < (fcs ? 60 : 64)) begin exp_byte(8'h00); c = ref_crc(c, 8'h00); total++; end
      if (fcs) for (int k = 0; k < 4; k++) exp_byte(~c[8*k +: 8]);
    end
    exp_len = expq.size();
    drive_fifo();
  endtask

  task automatic wait_end(input string req);
    int t;
    t = 0;
    while (done_cnt == 0 && unr_cnt == 0 && t < 4000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    check(t < 4000, req, t, 4000);
  endtask

  task automatic frame_checks(input string req, input bit fcs, input bit eof);
    logic [31:0] r;
    check(mism == 0, req, mism, 0);
    check(en_cyc == exp_len, req, en_cyc, exp_len);
    check(rises == 1, "R9", rises, 1);
    check(done_cnt == (eof ? 1 : 0), "R9", done_cnt, eof ? 1 : 0);
    check(unr_cnt == (eof ? 0 : 1), "R10", unr_cnt, eof ? 0 : 1);
    check(fq.size() == 0, "R12", fq.size(), 0);
    if (fcs && eof) begin
      r = 32'hFFFF_FFFF;
      for (int i = 8; 2*i + 1 < gotq.size(); i++) r = ref_crc(r, {gotq[2*i+1], gotq[2*i]});
      check(r == 32'hDEBB20E3, "R4", int'(r), int'(32'hDEBB20E3));
    end
  endtask

  initial begin
    rst_n = 1'b0; chan_ok = 1'b0; pad_on = 1'b0; fcs_on = 1'b0; fill_thresh = 8'd1;
    drive_fifo();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(tx_en == 1'b0, "reset", tx_en, 0);
    check(tx_done == 1'b0, "reset", tx_done, 0);
    check(tx_underrun == 1'b0, "reset", tx_underrun, 0);
    check(fifo_rd == 1'b0, "reset", fifo_rd, 0);
    mon_on = 1'b1;

    // R1: below threshold, then permit low, then go; short frame padded (R5)
    clear_mon();
    pad_on = 1; fcs_on = 1; fill_thresh = 8'd30; chan_ok = 1;
    load_frame(20, 3, 1, 1, 1);
    repeat (30) @(negedge clk);
    check(en_cyc == 0, "R1", en_cyc, 0);
    chan_ok = 0; fill_thresh = 8'd20;
    repeat (30) @(negedge clk);
    check(en_cyc == 0, "R1", en_cyc, 0);
    chan_ok = 1;
    wait_end("R1");
    frame_checks("R5", 1, 1);

    // R3 R4: long frame, no pad needed
    clear_mon(); fill_thresh = 8'd70;
    load_frame(70, 11, 1, 1, 1);
    wait_end("R3"); frame_checks("R3", 1, 1);

    // R5 boundary: exactly 60 bytes
    clear_mon(); fill_thresh = 8'd60;
    load_frame(60, 5, 1, 1, 1);
    wait_end("R5"); frame_checks("R5", 1, 1);

    // R7: pad off, check sequence on
    clear_mon(); pad_on = 0; fill_thresh = 8'd20;
    load_frame(20, 9, 0, 1, 1);
    wait_end("R7"); frame_checks("R7", 1, 1);

    // R8: both off
    clear_mon(); fcs_on = 0; fill_thresh = 8'd12;
    load_frame(12, 21, 0, 0, 1);
    wait_end("R8"); frame_checks("R8", 0, 1);

    // R6: pad on, check sequence off
    clear_mon(); pad_on = 1; fill_thresh = 8'd10;
    load_frame(10, 40, 1, 0, 1);
    wait_end("R6"); frame_checks("R6", 0, 1);

    // R2: one-byte frame, all overhead visible
    clear_mon(); pad_on = 0; fcs_on = 1; fill_thresh = 8'd1;
    load_frame(1, 77, 0, 1, 1);
    wait_end("R2"); frame_checks("R2", 1, 1);

    // R11: selects change during the frame
    clear_mon(); pad_on = 1; fcs_on = 1; fill_thresh = 8'd30;
    load_frame(30, 2, 1, 1, 1);
    while (!tx_en) @(negedge clk);
    pad_on = 0; fcs_on = 0; fill_thresh = 8'd200;
    wait_end("R11"); frame_checks("R11", 1, 1);

    // R10: underrun, no end-of-frame byte
    clear_mon(); pad_on = 1; fcs_on = 1; fill_thresh = 8'd10;
    load_frame(10, 8, 1, 1, 0);
    wait_end("R10"); frame_checks("R10", 1, 0);

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule